// File: doc/BRIEF.md
# Four-Phase Pulse Width Meter

This block measures how long an asynchronous, single-shot input pulse stays high, at a resolution finer than one period of the base clock. It is fed four copies of one base clock whose rising edges are spaced a quarter period apart. Each of four lanes is clocked by its own copy and synchronises the pulse into its domain. While the synchronised pulse is high, the lane counts its own clock edges. The four lane counts together sample the pulse on a grid of quarter periods. Their sum is therefore the high time in quarter periods. At a 400 MHz base clock, one quarter period is about 600 ps.

The result is delivered in the 0-degree domain. When a lane sees the synchronised pulse fall, it freezes its count and raises a done flag. The done flag is synchronised into the 0-degree domain. After a fixed settling delay of two base cycles, the frozen counts are read and added. The sum is published with a one-cycle valid strobe. If any lane has saturated, a one-cycle overflow strobe is raised instead. The lanes are then cleared through a request/acknowledge exchange, and only after that do they accept the next rising edge. The target input repeats at about 500 kHz or slower, with a high time of roughly 0.5 to 1 us. No coherent averaging is assumed.

Top module: `phase_width_meter`

## Requirements
- R1: While `rst_n` is low, and after it is released with no pulse applied, `width_q` is 0 and both `width_valid` and `width_ovf` are 0. A reset applied during a pulse abandons that measurement, and the next pulse is measured correctly.
- R2: The rising edges of `clk_p90`, `clk_p180` and `clk_p270` trail those of `clk_p0` by one, two and three quarter periods. Each lane counts the rising edges of its clock at which the pulse is high. `width_q` equals the sum of the four lane counts, which is the number of quarter-period sample points strictly inside the pulse. Two pulses whose falling edges differ by exactly one quarter period give widths that differ by exactly 1.
- R3: Each lane counter saturates at 2^CNT_W-1. If any lane is saturated when the result is formed, `width_ovf` pulses for one cycle, `width_valid` stays low, and `width_q` keeps its previous value.
- R4: `width_valid` is high for exactly one `clk_p0` cycle per measurement. `width_q` changes only in a cycle where `width_valid` is high.
- R5: The registered `width_valid` (or `width_ovf`) rises no later than 10 base cycles (80 ns at 125 MHz) after the pulse's falling edge. A result is only ever produced after at least one lane has seen the pulse end.
- R6: After each result, all lane counts are cleared before a new rising edge is accepted. A pulse that rises 20 or more base cycles after the previous result is measured on its own, without accumulating earlier counts.
- R7: A pulse that contains no quarter-period sample point produces no result. It also leaves the next measurement unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_p0 | input | 1 | Base clock, 0-degree phase. All outputs are in this domain. |
| clk_p90 | input | 1 | Base clock delayed by a quarter period |
| clk_p180 | input | 1 | Base clock delayed by half a period |
| clk_p270 | input | 1 | Base clock delayed by three quarter periods |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| pulse_in | input | 1 | Asynchronous pulse to be measured |
| width_q | output | CNT_W+2 | Last measured high time in quarter periods |
| width_valid | output | 1 | One-cycle strobe marking a new `width_q` |
| width_ovf | output | 1 | One-cycle strobe marking a saturated measurement |

## Verification
A lane stuck counting, or one that is never cleared, shows up at the ports as a width that is off by whole lane counts. This appears at the first result, or at the result of the following pulse if the clear step is broken. A quarter-period timing error appears as a width off by one, and the paired pulses one quarter apart expose it. A stuck control sequence shows up as a missing strobe within ten cycles of the falling edge. A wrong saturation path shows up as a valid strobe where an overflow strobe was due, or as a changed width after an overflow.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  typedef enum logic [1:0] {LANE_IDLE, LANE_COUNT, LANE_HELD} lane_state_t;
  typedef enum logic [1:0] {CTL_WAIT, CTL_SETTLE, CTL_EMIT, CTL_CLEAR} ctl_state_t;
endpackage

// File: rtl/pwm_sync.sv
`timescale 1ns/1ps
module pwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwm_lane.sv
`timescale 1ns/1ps
module pwm_lane
  import pwm_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_async,
  input  logic             clr_async,
  output logic [CNT_W-1:0] cnt,
  output logic             done,
  output logic             sat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic        pulse_s;
  logic        clr_s;
  logic        pulse_d;
  lane_state_t st;

  pwm_sync #(.STAGES(SYNC_STAGES)) i_pulse_sync (
    .clk(clk), .rst_n(rst_n), .d(pulse_async), .q(pulse_s));
  pwm_sync #(.STAGES(SYNC_STAGES)) i_clr_sync (
    .clk(clk), .rst_n(rst_n), .d(clr_async), .q(clr_s));

  // Rising edge of the synchronised pulse, only while armed.
  logic start_evt;
  assign start_evt = !clr_s && pulse_s && !pulse_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= LANE_IDLE;
      cnt     <= '0;
      pulse_d <= 1'b0;
    end else begin
      pulse_d <= pulse_s;
      case (st)
        LANE_IDLE: begin
          if (start_evt) begin
            st  <= LANE_COUNT;
            cnt <= CNT_W'(1);
          end
        end
        LANE_COUNT: begin
          if (pulse_s) begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          end else begin
            st <= LANE_HELD;
          end
        end
        LANE_HELD: begin
          if (clr_s) begin
            st  <= LANE_IDLE;
            cnt <= '0;
          end
        end
        default: st <= LANE_IDLE;
      endcase
    end
  end

  assign done = (st == LANE_HELD);
  assign sat  = (cnt == CNT_MAX);
endmodule

// File: rtl/pwm_ctrl.sv
`timescale 1ns/1ps
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int N_PHASE     = 4,
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE      = 2,
  parameter int SUM_W       = CNT_W + $clog2(N_PHASE)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_PHASE-1:0]              done_async,
  input  logic [N_PHASE-1:0][CNT_W-1:0]   lane_cnt,
  input  logic [N_PHASE-1:0]              lane_sat,
  output logic [SUM_W-1:0]                width_q,
  output logic                            width_valid,
  output logic                            width_ovf,
  output logic                            clr_req,
  output logic                            any_done_s
);
  localparam int SW = (SETTLE < 2) ? 1 : $clog2(SETTLE);

  logic [N_PHASE-1:0] done_s;
  logic [SW-1:0]      settle_cnt;
  ctl_state_t         st;

  for (genvar i = 0; i < N_PHASE; i++) begin : g_done_sync
    pwm_sync #(.STAGES(SYNC_STAGES)) i_done_sync (
      .clk(clk), .rst_n(rst_n), .d(done_async[i]), .q(done_s[i]));
  end

  assign any_done_s = |done_s;

  // Width in quarter periods: sum of the frozen lane counts.
  function automatic logic [SUM_W-1:0] total_width(
      input logic [N_PHASE-1:0][CNT_W-1:0] c);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N_PHASE; i++) acc = acc + SUM_W'(c[i]);
    return acc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= CTL_WAIT;
      settle_cnt  <= '0;
      width_q     <= '0;
      width_valid <= 1'b0;
      width_ovf   <= 1'b0;
      clr_req     <= 1'b0;
    end else begin
      width_valid <= 1'b0;
      width_ovf   <= 1'b0;
      case (st)
        CTL_WAIT: begin
          if (any_done_s) begin
            st         <= CTL_SETTLE;
            settle_cnt <= '0;
          end
        end
        CTL_SETTLE: begin
          if (settle_cnt == SW'(SETTLE - 1)) begin
            st <= CTL_EMIT;
            if (|lane_sat) begin
              width_ovf <= 1'b1;
            end else begin
              width_valid <= 1'b1;
              width_q     <= total_width(lane_cnt);
            end
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        CTL_EMIT: begin
          st      <= CTL_CLEAR;
          clr_req <= 1'b1;
        end
        CTL_CLEAR: begin
          if (!any_done_s) begin
            st      <= CTL_WAIT;
            clr_req <= 1'b0;
          end
        end
        default: st <= CTL_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/phase_width_meter.sv
`timescale 1ns/1ps
module phase_width_meter #(
  parameter int CNT_W         = 12,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 2
) (
  input  logic             clk_p0,
  input  logic             clk_p90,
  input  logic             clk_p180,
  input  logic             clk_p270,
  input  logic             rst_n,
  input  logic             pulse_in,
  output logic [CNT_W+1:0] width_q,
  output logic             width_valid,
  output logic             width_ovf
);
  localparam int N_PHASE = 4;
  localparam int SUM_W   = CNT_W + $clog2(N_PHASE);

  logic [N_PHASE-1:0]            lane_clk;
  logic [N_PHASE-1:0]            lane_done;
  logic [N_PHASE-1:0]            lane_sat;
  logic [N_PHASE-1:0][CNT_W-1:0] lane_cnt;
  logic                          clr_req;
  logic                          any_done_s;

  assign lane_clk = {clk_p270, clk_p180, clk_p90, clk_p0};

  for (genvar i = 0; i < N_PHASE; i++) begin : g_lane
    pwm_lane #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_lane (
      .clk         (lane_clk[i]),
      .rst_n       (rst_n),
      .pulse_async (pulse_in),
      .clr_async   (clr_req),
      .cnt         (lane_cnt[i]),
      .done        (lane_done[i]),
      .sat         (lane_sat[i])
    );
  end

  pwm_ctrl #(
    .N_PHASE(N_PHASE), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES),
    .SETTLE(SETTLE_CYCLES), .SUM_W(SUM_W)
  ) i_ctrl (
    .clk         (clk_p0),
    .rst_n       (rst_n),
    .done_async  (lane_done),
    .lane_cnt    (lane_cnt),
    .lane_sat    (lane_sat),
    .width_q     (width_q),
    .width_valid (width_valid),
    .width_ovf   (width_ovf),
    .clr_req     (clr_req),
    .any_done_s  (any_done_s)
  );
endmodule

// File: rtl/pwm_checker.sv
`timescale 1ns/1ps
module pwm_checker #(
  parameter int SUM_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             width_valid,
  input logic             width_ovf,
  input logic             clr_req,
  input logic             any_done_s,
  input logic [SUM_W-1:0] width_q
);
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    width_ovf |-> !width_valid);

  assert_ovf_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    width_ovf |=> !width_ovf);

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    width_valid |=> !width_valid);

  assert_width_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !width_valid |-> $stable(width_q));

  assert_result_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (width_valid || width_ovf) |-> any_done_s);

  assert_clear_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (width_valid || width_ovf) |=> clr_req);
endmodule

bind phase_width_meter pwm_checker #(.SUM_W(CNT_W + 2)) i_pwm_checker (
  .clk         (clk_p0),
  .rst_n       (rst_n),
  .width_valid (width_valid),
  .width_ovf   (width_ovf),
  .clr_req     (clr_req),
  .any_done_s  (any_done_s),
  .width_q     (width_q)
);

// File: tb/test_phase_width_meter.sv
`timescale 1ns/1ps
module test_phase_width_meter;
  localparam int CNT_W   = 12;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk_p0 = 1'b0;
  logic clk_p90 = 1'b0;
  logic clk_p180;
  logic clk_p270;
  logic rst_n = 1'b0;
  logic pulse_in = 1'b0;
  logic [CNT_W+1:0] width_q;
  logic width_valid;
  logic width_ovf;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // 125 MHz: period 8 ns, phases 2 ns apart. Rising edges mod 8: p0=4, p90=6, p180=0, p270=2.
  initial forever #4 clk_p0 = ~clk_p0;
  initial begin
    #6;
    forever begin
      clk_p90 = ~clk_p90;
      #4;
    end
  end
  assign clk_p180 = ~clk_p0;
  assign clk_p270 = ~clk_p90;

  phase_width_meter #(.CNT_W(CNT_W)) i_phase_width_meter (
    .clk_p0(clk_p0), .clk_p90(clk_p90), .clk_p180(clk_p180), .clk_p270(clk_p270),
    .rst_n(rst_n), .pulse_in(pulse_in),
    .width_q(width_q), .width_valid(width_valid), .width_ovf(width_ovf));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sample points of each phase strictly inside (t_rise, t_fall), capped per lane.
  function automatic int expect_quarters(real t_rise, real t_fall);
    int total = 0;
    for (int ph = 0; ph < 4; ph++) begin
      real off = 4.0 + 2.0 * ph;
      int n = int'($floor((t_fall - off) / 8.0)) - int'($floor((t_rise - off) / 8.0));
      if (n > CNT_MAX) n = CNT_MAX;
      total += n;
    end
    return total;
  endfunction

  task automatic run_pulse(input real gap, input real high, output real t_rise, output real t_fall);
    @(negedge clk_p0);
    #(gap);
    t_rise = $realtime;
    pulse_in = 1'b1;
    #(high);
    t_fall = $realtime;
    pulse_in = 1'b0;
  endtask

  task automatic await_result(output bit got_v, output bit got_o, output real t_seen);
    got_v = 1'b0;
    got_o = 1'b0;
    t_seen = 0.0;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk_p0);
      if (width_valid || width_ovf) begin
        got_v = width_valid;
        got_o = width_ovf;
        t_seen = $realtime - 4.0;
        break;
      end
    end
  endtask

  task automatic test_measure(input real high, output int width_seen);
    real tr, tf, ts;
    bit gv, go;
    int exp;
    run_pulse(300.3, high, tr, tf);
    exp = expect_quarters(tr, tf);
    await_result(gv, go, ts);
    check(gv, "R5 valid after fall", int'(gv), 1);
    check(!go, "R3 no overflow", int'(go), 0);
    check(gv && (ts - tf) <= 80.0, "R5 latency ns", int'(ts - tf), 80);
    check(int'(width_q) == exp, "R2 width", int'(width_q), exp);
    width_seen = int'(width_q);
    @(negedge clk_p0);
    check(!width_valid, "R4 single-cycle valid", int'(width_valid), 0);
  endtask

  task automatic test_reset_state();
    #20.3;
    check(width_q == '0 && !width_valid && !width_ovf, "R1 in reset", int'(width_q), 0);
    #20.0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk_p0);
    check(width_q == '0 && !width_valid && !width_ovf, "R1 after release", int'(width_q), 0);
  endtask

  task automatic test_resolution();
    int w1, w2;
    test_measure(301.1, w1);
    repeat (30) @(negedge clk_p0);
    test_measure(303.1, w2);
    check(w2 - w1 == 1, "R2 quarter step", w2 - w1, 1);
  endtask

  task automatic test_glitch();
    int w;
    bit seen = 1'b0;
    repeat (30) @(negedge clk_p0);
    #0.3;
    pulse_in = 1'b1;
    #1.2;
    pulse_in = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk_p0);
      if (width_valid || width_ovf) seen = 1'b1;
    end
    check(!seen, "R7 glitch gives no result", int'(seen), 0);
    test_measure(700.45, w);
    check(w > 0, "R7 next measurement intact", w, 1);
  endtask

  task automatic test_overflow();
    real tr, tf, ts;
    bit gv, go;
    int prev;
    int w;
    prev = int'(width_q);
    run_pulse(300.3, 33000.4, tr, tf);
    await_result(gv, go, ts);
    check(go, "R3 overflow strobe", int'(go), 1);
    check(!gv, "R3 valid suppressed", int'(gv), 0);
    check(int'(width_q) == prev, "R3 width held", int'(width_q), prev);
    @(negedge clk_p0);
    check(!width_ovf, "R3 single-cycle overflow", int'(width_ovf), 0);
    test_measure(1000.4, w);
    check(w < 600, "R6 cleared after overflow", w, 500);
  endtask

  task automatic test_reset_mid_pulse();
    int w;
    @(negedge clk_p0);
    #100.3;
    pulse_in = 1'b1;
    #200.0;
    rst_n = 1'b0;
    #3.0;
    check(width_q == '0 && !width_valid && !width_ovf, "R1 reset mid pulse", int'(width_q), 0);
    #100.0;
    pulse_in = 1'b0;
    #50.0;
    rst_n = 1'b1;
    repeat (20) @(negedge clk_p0);
    check(!width_valid && !width_ovf, "R1 no stale result", int'(width_valid), 0);
    test_measure(640.7, w);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    int w;
    test_reset_state();
    test_measure(1000.4, w);          // R2 nominal 1 us
    repeat (30) @(negedge clk_p0);
    test_measure(500.25, w);          // R2, R6 back-to-back
    repeat (30) @(negedge clk_p0);
    test_measure(5.1, w);             // R2 shortest measurable
    repeat (30) @(negedge clk_p0);
    test_resolution();
    test_glitch();
    repeat (30) @(negedge clk_p0);
    test_overflow();
    repeat (30) @(negedge clk_p0);
    test_reset_mid_pulse();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule